// File: doc/BRIEF.md
# I2C Master Byte Sequencer

This block is the master side of a two-wire serial bus, controlled through four small registers. Software brings the bus into use by setting a master bit, which makes the block drive a START condition. It then writes the 7-bit slave address with the direction bit into the data register. After that it either writes further bytes or reads them back one at a time. After each byte the block holds the clock line low, latches the ninth (acknowledge) bit and raises an interrupt. Clearing the master bit between bytes ends the transfer with a STOP condition.

A read does not need an explicit STOP. Software arms a no-acknowledge bit before the data-register read that launches the final byte. The engine does not acknowledge that byte, drives STOP on its own and clears the master bit. A repeat-start request between bytes issues a fresh START while the bus stays owned, so a write phase can be followed directly by a read phase. Both lines are open-drain: the block only reports when it pulls each line low and observes the resolved line levels. SCL timing comes from a programmable divider.

Register map (2-bit address): 0 = control, 1 = status, 2 = data, 3 = divider.

Top module: `i2cm_seq`

## Requirements
- R1: After reset both line drivers are released, the control, status and data registers read 0, the divider reads its reset parameter, and `irq` is low.
- R2: Writing control bit 0 (master) from 0 to 1 while the bus is idle makes SDA fall while SCL is high, and SCL is then driven low. Writing bit 0 from 1 to 0 while the engine waits between bytes makes SDA rise while SCL is high.
- R3: Outside START and STOP, SDA never changes in the same clock as SCL, nor while SCL is high. Every SCL high or low interval lasts at least max(divider, 2) clocks.
- R4: With control bit 1 (transmit) set, writing the data register between bytes sends the byte MSB first and samples the ninth bit. Status bit 1 then holds that sampled level, where 1 means the slave did not acknowledge.
- R5: With control bit 1 clear, reading the data register between bytes returns the last received byte and starts reception of the next byte. The master pulls the ninth bit low (acknowledge) unless control bit 2 is set.
- R6: A received byte started while control bit 2 (no-acknowledge) is set is not acknowledged. The engine then drives STOP by itself and control bit 0 reads back 0. A single-byte read works by arming bit 2 before the dummy data read.
- R7: Writing control with bit 0 and bit 3 (repeat start) set while between bytes drives a new START with no STOP before it, and status bit 2 stays set.
- R8: The pending flag (status bit 0, also the `irq` output) sets on the clock edge at which SCL is driven low after the ninth bit of each byte. Any status write clears it.
- R9: Status bit 2 (bus busy) sets when a START is seen on the lines and clears when a STOP is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (data-register reads have side effects) |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| irq | output | 1 | Byte-complete interrupt |
| scl_in | input | 1 | Resolved SCL line level |
| sda_in | input | 1 | Resolved SDA line level |
| scl_low_o | output | 1 | 1 pulls SCL low |
| sda_low_o | output | 1 | 1 pulls SDA low |

## Verification
The hardest state to reach is the auto-terminated read. The no-acknowledge bit must be armed between two particular data-register reads, and the engine must then both withhold the acknowledge and drive STOP with no further software action. The bench reaches it with a behavioural slave on the lines that serves bytes from a queue and logs the master's acknowledge per byte. The read sequence is written so the arming write falls before the next-to-last read, and again before the dummy read of a one-byte transfer. A repeated START inside a live transfer, and a not-acknowledged write caused by a wrong address and by a refused byte, are reached the same way.

// File: rtl/i2cm_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the I2C master sequencer.
// Assumes: register addresses are two bits wide and data is one byte.
package i2cm_pkg;
    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_STAT = 2'd1;
    localparam logic [1:0] A_DATA = 2'd2;
    localparam logic [1:0] A_DIV  = 2'd3;

    // Control bit positions
    localparam int C_MST   = 0;
    localparam int C_TX    = 1;
    localparam int C_NOACK = 2;
    localparam int C_RSTA  = 3;

    // Line engine states
    typedef enum logic [2:0] {
        E_IDLE,
        E_START,
        E_RSTART,
        E_STOP,
        E_BIT,
        E_HOLD
    } eng_st_t;
endpackage

// File: rtl/i2cm_tick.sv
`timescale 1ns/1ps
// Step timer: pulses `done` on the last clock of each step of div_eff clocks.
// Assumes: div_eff >= 2; restart holds the count at zero while no step runs.
module i2cm_tick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [DIV_W-1:0] div_eff,
    output logic             done
);
    localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

    logic [DIV_W-1:0] cnt;

    assign done = (cnt == div_eff - ONE);

    // Count clocks within the current step
    always_ff @(posedge clk) begin
        if (!rst_n || restart || done) cnt <= '0;
        else                           cnt <= cnt + ONE;
    end
endmodule

// File: rtl/i2cm_bits.sv
`timescale 1ns/1ps
// Line engine: produces START, repeated START, STOP and 9-bit byte cells on
// the open-drain SCL/SDA drivers, each step lasting div_eff clocks.
// Assumes: single master, no clock stretching, sda_in already synchronous.
module i2cm_bits
    import i2cm_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] div_eff,
    input  logic             cmd_start,
    input  logic             cmd_rstart,
    input  logic             cmd_stop,
    input  logic             cmd_byte,
    input  logic             byte_tx,
    input  logic [7:0]       tx_data,
    input  logic             send_ack,
    input  logic             sda_in,
    output logic             scl_low_o,
    output logic             sda_low_o,
    output logic             byte_done,
    output logic [7:0]       rx_data,
    output logic             ack_bit,
    output logic             eng_idle,
    output logic             eng_hold,
    output logic             running
);
    eng_st_t     st;
    logic [1:0]  sub, last_sub;
    logic [3:0]  bitn;
    logic [7:0]  shreg;
    logic        is_tx, ack_low_q, scl_w, sda_w, bit_drv, step_done;
    logic        scl_low_q, sda_low_q;

    assign eng_idle  = (st == E_IDLE);
    assign eng_hold  = (st == E_HOLD);
    assign running   = !eng_idle && !eng_hold;
    assign rx_data   = shreg;
    assign scl_low_o = scl_low_q;
    assign sda_low_o = sda_low_q;

    i2cm_tick #(.DIV_W(DIV_W)) u_tick (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (!running),
        .div_eff (div_eff),
        .done    (step_done)
    );

    // Level the current cell wants on SDA
    assign bit_drv = (bitn == 4'd8) ? (!is_tx && ack_low_q) : (is_tx && !shreg[7]);

    // Wanted line levels for the current state and step
    always_comb begin
        last_sub = 2'd2;
        scl_w    = 1'b0;
        sda_w    = 1'b0;
        case (st)
            E_HOLD:   begin scl_w = 1'b1;         sda_w = sda_low_q;    end
            E_START:  begin scl_w = 1'b0;         sda_w = (sub != 2'd0); last_sub = 2'd1; end
            E_RSTART: begin scl_w = (sub == 2'd0); sda_w = (sub == 2'd2); end
            E_STOP:   begin scl_w = (sub == 2'd0); sda_w = (sub != 2'd2); end
            E_BIT:    begin scl_w = (sub == 2'd0); sda_w = bit_drv;     last_sub = 2'd1; end
            default:  begin scl_w = 1'b0;         sda_w = 1'b0;         end
        endcase
    end

    // Output stage: SDA may not move on the edge that pulls SCL low
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_low_q <= 1'b0;
            sda_low_q <= 1'b0;
        end else begin
            scl_low_q <= scl_w;
            sda_low_q <= (scl_w && !scl_low_q) ? sda_low_q : sda_w;
        end
    end

    // State sequencing, shifting and acknowledge sampling
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= E_IDLE;
            sub       <= 2'd0;
            bitn      <= 4'd0;
            shreg     <= 8'd0;
            is_tx     <= 1'b0;
            ack_low_q <= 1'b0;
            ack_bit   <= 1'b0;
            byte_done <= 1'b0;
        end else begin
            byte_done <= 1'b0;
            case (st)
                E_IDLE: if (cmd_start) begin st <= E_START; sub <= 2'd0; end
                E_HOLD: begin
                    if (cmd_stop)        begin st <= E_STOP;   sub <= 2'd0; end
                    else if (cmd_rstart) begin st <= E_RSTART; sub <= 2'd0; end
                    else if (cmd_byte) begin
                        st        <= E_BIT;
                        sub       <= 2'd0;
                        bitn      <= 4'd0;
                        is_tx     <= byte_tx;
                        ack_low_q <= send_ack;
                        shreg     <= tx_data;
                    end
                end
                default: if (step_done) begin
                    if (sub != last_sub) sub <= sub + 2'd1;
                    else begin
                        sub <= 2'd0;
                        case (st)
                            E_START, E_RSTART: st <= E_HOLD;
                            E_STOP:            st <= E_IDLE;
                            default: begin
                                if (bitn == 4'd8) begin
                                    st        <= E_HOLD;
                                    ack_bit   <= sda_in;
                                    byte_done <= 1'b1;
                                end else begin
                                    shreg <= {shreg[6:0], sda_in};
                                    bitn  <= bitn + 4'd1;
                                end
                            end
                        endcase
                    end
                end
            endcase
        end
    end

    // Checker counter: clocks since SCL last changed
    logic [15:0] hold_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n || (scl_low_q != scl_w)) hold_cnt <= 16'd0;
        else if (hold_cnt != 16'hFFFF)       hold_cnt <= hold_cnt + 16'd1;
    end

    p_scl_fall_sda_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_low_q) |-> $stable(sda_low_q));
    p_scl_rise_sda_steady_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scl_low_q) |-> $stable(sda_low_q));
    p_half_period_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_low_q != scl_w) |-> (hold_cnt >= 16'(div_eff) - 16'd1));
endmodule

// File: rtl/i2cm_busmon.sv
`timescale 1ns/1ps
// Bus monitor: tracks START/STOP conditions on the resolved lines.
// Assumes: line inputs are synchronous to clk; idle bus is high on both.
module i2cm_busmon (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic busy
);
    logic scl_p, sda_p, saw_start, saw_stop;

    assign saw_start = scl_in && scl_p &&  sda_p && !sda_in;
    assign saw_stop  = scl_in && scl_p && !sda_p &&  sda_in;

    // Previous line levels and busy flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
            busy  <= 1'b0;
        end else begin
            scl_p <= scl_in;
            sda_p <= sda_in;
            if (saw_start)     busy <= 1'b1;
            else if (saw_stop) busy <= 1'b0;
        end
    end

    p_busy_follows_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        saw_start |=> busy);
endmodule

// File: rtl/i2cm_seq.sv
`timescale 1ns/1ps
// I2C master byte sequencer: register front end over the line engine.
// Assumes: 7-bit addressing, single master; software writes the divider
// only while the bus is idle.
module i2cm_seq
    import i2cm_pkg::*;
#(
    parameter int               DIV_W     = 8,
    parameter logic [DIV_W-1:0] DIV_RESET = DIV_W'(50)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       scl_low_o,
    output logic       sda_low_o
);
    localparam logic [DIV_W-1:0] DIV_MIN = DIV_W'(2);

    logic             mst_q, tx_q, noack_q, irq_q, nak_q, cur_tx_q, rx_nak_q;
    logic [7:0]       rxbuf_q, rx_data;
    logic [DIV_W-1:0] div_q, div_eff;
    logic             wr_ctrl, wr_stat, data_go;
    logic             cmd_start, cmd_rstart, cmd_stop, cmd_byte, auto_stop;
    logic             byte_done, ack_bit, eng_idle, eng_hold, running, bus_busy;

    assign div_eff   = (div_q < DIV_MIN) ? DIV_MIN : div_q;
    assign wr_ctrl   = reg_wr && (reg_addr == A_CTRL);
    assign wr_stat   = reg_wr && (reg_addr == A_STAT);
    assign data_go   = (reg_wr && (reg_addr == A_DATA) &&  tx_q)
                     || (reg_rd && (reg_addr == A_DATA) && !tx_q);
    assign auto_stop = byte_done && rx_nak_q;

    // Commands to the line engine
    assign cmd_start  = wr_ctrl && !mst_q && reg_wdata[C_MST] && eng_idle;
    assign cmd_stop   = (wr_ctrl && mst_q && !reg_wdata[C_MST] && eng_hold) || auto_stop;
    assign cmd_rstart = wr_ctrl && mst_q && reg_wdata[C_MST] && reg_wdata[C_RSTA] && eng_hold;
    assign cmd_byte   = data_go && mst_q && eng_hold;
    assign irq        = irq_q;

    i2cm_bits #(.DIV_W(DIV_W)) u_bits (
        .clk        (clk),
        .rst_n      (rst_n),
        .div_eff    (div_eff),
        .cmd_start  (cmd_start),
        .cmd_rstart (cmd_rstart),
        .cmd_stop   (cmd_stop),
        .cmd_byte   (cmd_byte),
        .byte_tx    (tx_q),
        .tx_data    (reg_wdata),
        .send_ack   (!noack_q),
        .sda_in     (sda_in),
        .scl_low_o  (scl_low_o),
        .sda_low_o  (sda_low_o),
        .byte_done  (byte_done),
        .rx_data    (rx_data),
        .ack_bit    (ack_bit),
        .eng_idle   (eng_idle),
        .eng_hold   (eng_hold),
        .running    (running)
    );

    i2cm_busmon u_mon (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .busy   (bus_busy)
    );

    // Register state, byte bookkeeping and interrupt flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mst_q    <= 1'b0;
            tx_q     <= 1'b0;
            noack_q  <= 1'b0;
            irq_q    <= 1'b0;
            nak_q    <= 1'b0;
            cur_tx_q <= 1'b0;
            rx_nak_q <= 1'b0;
            rxbuf_q  <= 8'd0;
            div_q    <= DIV_RESET;
        end else begin
            if (wr_ctrl) begin
                mst_q   <= reg_wdata[C_MST];
                tx_q    <= reg_wdata[C_TX];
                noack_q <= reg_wdata[C_NOACK];
            end
            if (auto_stop) mst_q <= 1'b0;
            if (reg_wr && (reg_addr == A_DIV)) div_q <= reg_wdata[DIV_W-1:0];
            if (cmd_byte) begin
                cur_tx_q <= tx_q;
                rx_nak_q <= !tx_q && noack_q;
            end
            if (byte_done) begin
                if (cur_tx_q) nak_q   <= ack_bit;
                else          rxbuf_q <= rx_data;
            end
            if (byte_done)    irq_q <= 1'b1;
            else if (wr_stat) irq_q <= 1'b0;
        end
    end

    // Read-data multiplexer
    always_comb begin
        case (reg_addr)
            A_CTRL:  reg_rdata = {5'd0, noack_q, tx_q, mst_q};
            A_STAT:  reg_rdata = {4'd0, running, bus_busy, nak_q, irq_q};
            A_DATA:  reg_rdata = rxbuf_q;
            default: reg_rdata = 8'(div_q);
        endcase
    end

    p_irq_on_scl_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_q) |-> $rose(scl_low_o));
    p_irq_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && !byte_done) |=> !irq_q);
    p_rstart_keeps_bus_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_rstart |-> bus_busy);
    p_autostop_engages_r6: assert property (@(posedge clk) disable iff (!rst_n)
        auto_stop |=> (running && !mst_q));
endmodule

// File: tb/i2cm_seq_test.sv
`timescale 1ns/1ps
module i2cm_seq_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       irq, scl_low_o, sda_low_o;
    logic       slv_low = 1'b0;
    logic       scl, sda;

    int tests = 0, fails = 0;
    int div_cur = 50;

    always #2 clk = ~clk;

    assign scl = !scl_low_o;
    assign sda = !(sda_low_o || slv_low);

    i2cm_seq uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .scl_in(scl), .sda_in(sda),
        .scl_low_o(scl_low_o), .sda_low_o(sda_low_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- behavioural slave (address 0x5A) ----------------
    localparam logic [6:0] SADDR = 7'h5A;
    logic [7:0] rd_q[$] = '{8'hA5, 8'h5A, 8'hC3, 8'h96};
    logic [7:0] got_q[$];
    logic [7:0] addr_q[$];
    bit         mack_q[$];
    int  n_start = 0, n_stop = 0;
    int  bitc = 0, sph = 0;        // 0 idle,1 addr,2 write,3 read,4 ignore
    bit  first = 0, mack = 0, sending = 0;
    logic [7:0] sh = 0, txb = 0;
    logic pscl = 1, psda = 1;

    always @(negedge clk) begin
        if (!rst_n) begin
            pscl = 1; psda = 1; slv_low = 0; sph = 0;
        end else begin
            if (scl && pscl && psda && !sda) begin
                n_start++; sph = 1; bitc = 0; slv_low = 0; first = 0;
            end else if (scl && pscl && !psda && sda) begin
                n_stop++; sph = 0; slv_low = 0;
            end else if (scl && !pscl) begin
                if (bitc < 8) sh = {sh[6:0], sda};
                else if (sph == 3 && !first) begin mack = !sda; mack_q.push_back(mack); end
                bitc++;
            end else if (!scl && pscl) begin
                if (bitc == 8) begin
                    case (sph)
                        1: begin
                            addr_q.push_back(sh);
                            if (sh[7:1] == SADDR) begin
                                slv_low = 1; sph = sh[0] ? 3 : 2; first = 1;
                            end else sph = 4;
                        end
                        2: begin got_q.push_back(sh); slv_low = (sh != 8'hFF); end
                        default: slv_low = 0;
                    endcase
                end else if (bitc == 9) begin
                    bitc = 0; slv_low = 0; sending = 0;
                    if (sph == 3 && (first || mack) && rd_q.size() > 0) begin
                        txb = rd_q.pop_front(); slv_low = !txb[7]; sending = 1;
                    end
                    first = 0;
                end else if (bitc >= 1 && bitc <= 7 && sph == 3 && sending) begin
                    slv_low = !txb[7-bitc];
                end
            end
            pscl = scl; psda = sda;
        end
    end

    // ---------------- per-clock reference model ----------------
    int  r3_mis = 0, irq_mis = 0, run = 1000, rcount = 0;
    bit  mirq = 0, clr_pend = 0;
    logic mscl = 1, msda = 1;

    always @(posedge clk) begin
        #1;
        if (!rst_n) begin
            mirq = 0; rcount = 0; mscl = 1; msda = 1; run = 1000;
        end else begin
            if (scl != mscl && sda != msda) r3_mis++;
            if (scl && mscl && sda != msda) rcount = 0;
            if (clr_pend) begin mirq = 0; clr_pend = 0; end
            if (scl != mscl) begin
                if (run < div_cur) r3_mis++;
                run = 1;
                if (scl) rcount++;
                else if (rcount == 9) begin mirq = 1; rcount = 0; end
            end else run++;
            if (irq !== mirq) irq_mis++;
            mscl = scl; msda = sda;
        end
    end

    // ---------------- register access ----------------
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        if (a == 2'd1) clr_pend = 1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic wait_irq(input string req);
        int n = 0;
        while (!irq && n < 5000) begin @(negedge clk); n++; end
        check(irq === 1'b1, req, irq, 1);
        wr(2'd1, 8'h00);
    endtask

    task automatic wait_quiet();
        logic [7:0] s;
        for (int i = 0; i < 2000; i++) begin
            rd(2'd1, s);
            if (s[3] == 1'b0) break;
        end
        repeat (4) @(negedge clk);
    endtask

    logic [7:0] v;

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(scl_low_o == 0 && sda_low_o == 0 && irq == 0, "R1 lines/irq", {scl_low_o, sda_low_o, irq}, 0);
        rd(2'd0, v); check(v == 8'h00, "R1 ctrl", v, 0);
        rd(2'd1, v); check(v == 8'h00, "R1 status", v, 0);
        rd(2'd2, v); check(v == 8'h00, "R1 data", v, 0);
        rd(2'd3, v); check(v == 8'd50, "R1 divider", v, 50);

        wr(2'd3, 8'd3); div_cur = 3;
        // R2 START, R9 busy
        wr(2'd0, 8'h03);
        repeat (20) @(negedge clk);
        check(n_start == 1, "R2 start seen", n_start, 1);
        rd(2'd1, v); check(v[2] == 1'b1, "R9 busy after start", v, 8'h04);

        // R4 write transfer
        wr(2'd2, 8'hB4); wait_irq("R8 irq addr");
        rd(2'd1, v); check(v[1] == 1'b0, "R4 address acked", v[1], 0);
        check(addr_q.size() == 1 && addr_q[0] == 8'hB4, "R4 address bits", addr_q[0], 8'hB4);
        wr(2'd2, 8'h3C); wait_irq("R8 irq data");
        rd(2'd1, v); check(v[1] == 1'b0, "R4 data acked", v[1], 0);
        check(got_q.size() == 1 && got_q[0] == 8'h3C, "R4 data MSB first", got_q[0], 8'h3C);
        wr(2'd2, 8'hFF);
        begin
            int n = 0;
            while (!irq && n < 5000) begin @(negedge clk); n++; end
        end
        check(irq == 1'b1, "R8 irq pending", irq, 1);
        wr(2'd1, 8'h00);
        check(irq == 1'b0, "R8 status write clears", irq, 0);
        rd(2'd1, v); check(v[1] == 1'b1, "R4 refused byte nak", v[1], 1);

        // R7 repeated start then read
        wr(2'd0, 8'h0B);
        repeat (30) @(negedge clk);
        check(n_start == 2 && n_stop == 0, "R7 restart without stop", n_stop, 0);
        rd(2'd1, v); check(v[2] == 1'b1, "R7 busy held", v, 8'h04);
        wr(2'd2, 8'hB5); wait_irq("R8 irq raddr");
        wr(2'd0, 8'h01);
        rd(2'd2, v);                       // dummy read starts byte 0
        wait_irq("R8 irq rd0");
        rd(2'd2, v); check(v == 8'hA5, "R5 first byte", v, 8'hA5);
        wait_irq("R8 irq rd1");
        wr(2'd0, 8'h05);                   // arm no-acknowledge
        rd(2'd2, v); check(v == 8'h5A, "R5 second byte", v, 8'h5A);
        wait_irq("R8 irq rd2");
        wait_quiet();
        rd(2'd2, v); check(v == 8'hC3, "R5 last byte", v, 8'hC3);
        check(mack_q.size() == 3 && mack_q[0] && mack_q[1] && !mack_q[2], "R5 R6 ack pattern", mack_q.size(), 3);
        check(n_stop == 1, "R6 auto stop", n_stop, 1);
        rd(2'd0, v); check(v[0] == 1'b0, "R6 master bit cleared", v, 0);
        rd(2'd1, v); check(v[2] == 1'b0, "R9 busy cleared", v, 0);

        // R6 one-byte read with a slower divider (R3)
        wr(2'd3, 8'd5); div_cur = 5;
        wr(2'd0, 8'h03);
        repeat (30) @(negedge clk);
        wr(2'd2, 8'hB5); wait_irq("R8 irq 1b addr");
        wr(2'd0, 8'h05);
        rd(2'd2, v);
        wait_irq("R8 irq 1b");
        wait_quiet();
        rd(2'd2, v); check(v == 8'h96, "R6 one-byte read", v, 8'h96);
        check(mack_q.size() == 4 && !mack_q[3], "R6 one-byte nack", mack_q.size(), 4);
        check(n_stop == 2, "R6 one-byte stop", n_stop, 2);

        // R2 STOP after wrong address
        wr(2'd0, 8'h03);
        repeat (30) @(negedge clk);
        wr(2'd2, 8'h22); wait_irq("R8 irq wrong addr");
        rd(2'd1, v); check(v[1] == 1'b1, "R4 wrong address nak", v[1], 1);
        wr(2'd0, 8'h02);
        wait_quiet();
        check(n_stop == 3, "R2 software stop", n_stop, 3);
        rd(2'd1, v); check(v[2] == 1'b0, "R9 busy cleared after stop", v, 0);

        check(r3_mis == 0, "R3 line timing", r3_mis, 0);
        check(irq_mis == 0, "R8 irq model per clock", irq_mis, 0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule